// File: doc/BRIEF.md
# Single-Use Challenge-Response Verifier

This block is the checking side of a challenge/response authentication scheme built on a device fingerprint that has many answers. At enrollment, software or test equipment writes a table of challenge/response pairs into the block. Each slot is written with a challenge word and the response word the device is expected to give back. On each authentication request the block picks a live slot at random and presents its challenge. It then waits for the device's answer and compares it with the stored response, and reports pass or fail. The slot is then retired for good, so a recorded exchange can never be replayed against it.

The random pick uses a free-running shift-register sequence that supplies a starting slot. From that slot the block steps forward, wrapping at the end of the table, until it finds a slot that is loaded and not yet spent. If no such slot exists, a request is answered at once with an exhausted status and no challenge goes out. A device that stays silent for longer than a set number of cycles is failed, and its slot is still retired. A table sized for the device's whole service life is expected to be used only in small part.

Top module: `pair_verifier`

## Requirements
- R1: After reset, `busy`, `chal_valid` and `res_valid` are low, and no slot is loaded or spent.
- R2: An enrollment write loads the challenge and response at `enr_idx` and marks that slot loaded. The write is ignored while `busy` is high. It is also ignored when the slot is already spent, so a spent slot cannot be loaded again.
- R3: A `start` pulse in idle, with at least one live slot, raises `chal_valid` with the challenge of a live slot. The slot search begins at an index taken from a free-running LFSR and steps upward one slot per cycle with wrap-around. `chal_out` stays constant while `chal_valid` is high.
- R4: A `resp_valid` sampled while `chal_valid` is high ends the exchange. One cycle later `res_valid` is high for one cycle with `res_exh` = 0, and `chal_valid` and `busy` are low. `res_pass` = 1 when `resp_data` equals the stored response.
- R5: If `resp_data` differs from the stored response in any bit, the result has `res_pass` = 0.
- R6: Every completed exchange, whether pass, fail or timeout, marks its slot spent, and that slot's challenge is never issued again.
- R7: A `start` in idle with no live slot gives `res_valid` = 1, `res_exh` = 1 and `res_pass` = 0 one cycle later. No challenge is issued and `busy` stays low.
- R8: If no response arrives, `chal_valid` stays high for exactly TIMEOUT cycles. Then it drops, and in the same cycle a result with `res_pass` = 0 and `res_exh` = 0 appears.
- R9: `start` is ignored while `busy` is high. No second challenge and no second result come from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enr_we | input | 1 | Enrollment write strobe |
| enr_idx | input | IDX_W | Slot to load |
| enr_chal | input | CHAL_W | Challenge word to store |
| enr_resp | input | RESP_W | Expected response to store |
| start | input | 1 | Authentication request pulse |
| busy | output | 1 | An exchange is in progress |
| chal_valid | output | 1 | Challenge is being presented |
| chal_out | output | CHAL_W | Challenge word |
| resp_valid | input | 1 | Device response strobe |
| resp_data | input | RESP_W | Device response word |
| res_valid | output | 1 | One-cycle result strobe |
| res_pass | output | 1 | Response matched (valid with res_valid) |
| res_exh | output | 1 | No live slot was left (valid with res_valid) |

## Verification
An exhausted answer is due one cycle after the edge that samples `start`, so the bench reads it at the very next falling edge. A challenge appears after a search whose length depends on the random start. For that reason the bench waits for `chal_valid` and makes no cycle count for it. A pass or fail is due one cycle after the edge that samples `resp_valid`, and a silent device is failed after exactly TIMEOUT cycles of `chal_valid`. The bench counts those cycles, and a monitor takes each result off the expected-result queue at the falling edge where `res_valid` is seen.

// File: rtl/pv_pkg.sv
package pv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_WAIT = 2'd2
  } pv_state_t;
endpackage

// File: rtl/pv_lfsr.sv
module pv_lfsr #(
  parameter int          W    = 16,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] SEED = 16'h1D2B
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] value
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (rst) sr_q <= SEED;
    else     sr_q <= {1'b0, sr_q[W-1:1]} ^ (sr_q[0] ? TAPS : '0);
  end

  assign value = sr_q;
endmodule

// File: rtl/pv_store.sv
module pv_store #(
  parameter int IDX_W  = 6,
  parameter int CHAL_W = 32,
  parameter int RESP_W = 32,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [CHAL_W-1:0] wr_chal,
  input  logic [RESP_W-1:0] wr_resp,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [CHAL_W-1:0] rd_chal,
  output logic [RESP_W-1:0] rd_resp
);
  logic [CHAL_W-1:0] chal_mem [DEPTH];
  logic [RESP_W-1:0] resp_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      chal_mem[wr_idx] <= wr_chal;
      resp_mem[wr_idx] <= wr_resp;
    end
    rd_chal <= chal_mem[rd_idx];
    rd_resp <= resp_mem[rd_idx];
  end
endmodule

// File: rtl/pv_ledger.sv
module pv_ledger #(
  parameter int IDX_W = 6,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_en,
  input  logic [IDX_W-1:0] load_idx,
  input  logic             retire_en,
  input  logic [IDX_W-1:0] retire_idx,
  output logic [DEPTH-1:0] live,
  output logic [DEPTH-1:0] spent
);
  logic [DEPTH-1:0] loaded_q;
  logic [DEPTH-1:0] spent_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        loaded_q[i] <= 1'b0;
        spent_q[i]  <= 1'b0;
      end else begin
        if (load_en && load_idx == IDX_W'(i))     loaded_q[i] <= 1'b1;
        if (retire_en && retire_idx == IDX_W'(i)) spent_q[i]  <= 1'b1;
      end
    end
  end

  assign live  = loaded_q & ~spent_q;
  assign spent = spent_q;
endmodule

// File: rtl/pair_verifier.sv
module pair_verifier #(
  parameter int IDX_W   = 6,
  parameter int CHAL_W  = 32,
  parameter int RESP_W  = 32,
  parameter int TIMEOUT = 256,
  parameter int LFSR_W  = 16,
  localparam int DEPTH  = 1 << IDX_W,
  localparam int TMR_W  = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enr_we,
  input  logic [IDX_W-1:0]  enr_idx,
  input  logic [CHAL_W-1:0] enr_chal,
  input  logic [RESP_W-1:0] enr_resp,
  input  logic              start,
  output logic              busy,
  output logic              chal_valid,
  output logic [CHAL_W-1:0] chal_out,
  input  logic              resp_valid,
  input  logic [RESP_W-1:0] resp_data,
  output logic              res_valid,
  output logic              res_pass,
  output logic              res_exh
);
  import pv_pkg::*;

  pv_state_t         state_q;
  logic [IDX_W-1:0]  ptr_q;
  logic [TMR_W-1:0]  timer_q;
  logic [LFSR_W-1:0] rnd;
  logic [DEPTH-1:0]  live_vec;
  logic [DEPTH-1:0]  spent_vec;
  logic [RESP_W-1:0] stored_resp;
  logic              enr_ok;
  logic              expire;
  logic              finish_x;

  assign enr_ok   = enr_we && (state_q == ST_IDLE) && !spent_vec[enr_idx];
  assign expire   = (timer_q == TMR_W'(TIMEOUT - 1));
  assign finish_x = (state_q == ST_WAIT) && (resp_valid || expire);
  assign busy     = (state_q != ST_IDLE);

  pv_lfsr #(.W(LFSR_W)) u_rng (
    .clk   (clk),
    .rst   (rst),
    .value (rnd)
  );

  pv_store #(.IDX_W(IDX_W), .CHAL_W(CHAL_W), .RESP_W(RESP_W)) u_store (
    .clk     (clk),
    .wr_en   (enr_ok),
    .wr_idx  (enr_idx),
    .wr_chal (enr_chal),
    .wr_resp (enr_resp),
    .rd_idx  (ptr_q),
    .rd_chal (chal_out),
    .rd_resp (stored_resp)
  );

  pv_ledger #(.IDX_W(IDX_W)) u_ledger (
    .clk        (clk),
    .rst        (rst),
    .load_en    (enr_ok),
    .load_idx   (enr_idx),
    .retire_en  (finish_x),
    .retire_idx (ptr_q),
    .live       (live_vec),
    .spent      (spent_vec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      ptr_q      <= '0;
      timer_q    <= '0;
      chal_valid <= 1'b0;
      res_valid  <= 1'b0;
      res_pass   <= 1'b0;
      res_exh    <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            if (live_vec == '0) begin
              res_valid <= 1'b1;
              res_exh   <= 1'b1;
              res_pass  <= 1'b0;
            end else begin
              ptr_q   <= rnd[IDX_W-1:0];
              state_q <= ST_SCAN;
            end
          end
        end
        ST_SCAN: begin
          if (live_vec[ptr_q]) begin
            state_q    <= ST_WAIT;
            chal_valid <= 1'b1;
            timer_q    <= '0;
          end else begin
            ptr_q <= ptr_q + IDX_W'(1);
          end
        end
        ST_WAIT: begin
          if (finish_x) begin
            chal_valid <= 1'b0;
            res_valid  <= 1'b1;
            res_exh    <= 1'b0;
            res_pass   <= resp_valid && (resp_data == stored_resp);
            state_q    <= ST_IDLE;
          end else begin
            timer_q <= timer_q + TMR_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pv_checker.sv
module pv_checker #(
  parameter int DEPTH  = 64,
  parameter int CHAL_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              chal_valid,
  input logic [CHAL_W-1:0] chal_out,
  input logic              res_valid,
  input logic              res_pass,
  input logic              res_exh,
  input logic [DEPTH-1:0]  spent
);
  p_stable_chal_r3: assert property (@(posedge clk) disable iff (rst)
    chal_valid |=> (!chal_valid || $stable(chal_out)));

  p_retire_one_r6: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_exh) |-> ($countones(spent) == $countones($past(spent)) + 1));

  p_exh_fail_r7: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_exh) |-> (!res_pass && !chal_valid && !busy));

  p_exh_keeps_r7: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_exh) |-> $stable(spent));

  p_chal_busy_r9: assert property (@(posedge clk) disable iff (rst)
    chal_valid |-> busy);

  p_busy_from_start_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));
endmodule

bind pair_verifier pv_checker #(.DEPTH(DEPTH), .CHAL_W(CHAL_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .busy       (busy),
  .chal_valid (chal_valid),
  .chal_out   (chal_out),
  .res_valid  (res_valid),
  .res_pass   (res_pass),
  .res_exh    (res_exh),
  .spent      (spent_vec)
);

// File: tb/sim_pair_verifier.sv
`timescale 1ns/1ps
module sim_pair_verifier;
  localparam int IW = 4;
  localparam int D  = 1 << IW;
  localparam int CW = 16;
  localparam int RW = 16;
  localparam int TO = 20;
  localparam int NL = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          enr_we = 1'b0;
  logic [IW-1:0] enr_idx = '0;
  logic [CW-1:0] enr_chal = '0;
  logic [RW-1:0] enr_resp = '0;
  logic          start = 1'b0;
  logic          busy, chal_valid, res_valid, res_pass, res_exh;
  logic [CW-1:0] chal_out;
  logic          resp_valid = 1'b0;
  logic [RW-1:0] resp_data = '0;

  always #5 clk = ~clk;

  pair_verifier #(.IDX_W(IW), .CHAL_W(CW), .RESP_W(RW), .TIMEOUT(TO)) u0 (
    .clk(clk), .rst(rst), .enr_we(enr_we), .enr_idx(enr_idx),
    .enr_chal(enr_chal), .enr_resp(enr_resp), .start(start), .busy(busy),
    .chal_valid(chal_valid), .chal_out(chal_out), .resp_valid(resp_valid),
    .resp_data(resp_data), .res_valid(res_valid), .res_pass(res_pass),
    .res_exh(res_exh)
  );

  int checks = 0;
  int fails  = 0;
  int rises  = 0;
  bit used_m [D];
  logic [CW-1:0] chal_of [D];
  logic [RW-1:0] resp_of [D];
  bit exp_pass [$];
  bit exp_exh  [$];
  bit prev_cv = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int lookup(input logic [CW-1:0] c);
    for (int i = 0; i < NL; i++) if (chal_of[i] == c) return i;
    return -1;
  endfunction

  // monitor: challenge freshness and result scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (chal_valid && !prev_cv) begin
        int k;
        rises++;
        k = lookup(chal_out);
        chk(k >= 0 && !used_m[k >= 0 ? k : 0], "R3 R6 challenge from live slot", chal_out, k);
        if (k >= 0) used_m[k] = 1'b1;
      end
      if (res_valid) begin
        if (exp_pass.size() == 0) begin
          chk(1'b0, "R9 unexpected result", 1, 0);
        end else begin
          bit ep, ee;
          ep = exp_pass.pop_front();
          ee = exp_exh.pop_front();
          chk(res_pass == ep && res_exh == ee, "R2/R4/R5/R7 result fields",
              {res_pass, res_exh}, {ep, ee});
        end
      end
      prev_cv = chal_valid;
    end
  end

  task automatic enroll(input int i, input logic [CW-1:0] c, input logic [RW-1:0] r);
    enr_we = 1'b1; enr_idx = IW'(i); enr_chal = c; enr_resp = r;
    @(negedge clk);
    enr_we = 1'b0;
  endtask

  // mode 0: correct, 1: wrong, 2: silent, 3: correct with stray start/enroll
  task automatic auth(input int mode);
    int k;
    exp_pass.push_back(mode == 0 || mode == 3);
    exp_exh.push_back(1'b0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!chal_valid) @(negedge clk);
    k = lookup(chal_out);
    if (mode == 2) begin
      int cnt = 0;
      while (chal_valid) begin cnt++; @(negedge clk); end
      chk(cnt == TO, "R8 timeout length", cnt, TO);
      chk(!busy, "R8 idle after timeout", busy, 0);
    end else begin
      if (mode == 3) begin
        start = 1'b1; enr_we = 1'b1; enr_idx = IW'(12);
        enr_chal = 16'hDDDD; enr_resp = 16'h2222;
        @(negedge clk);
        start = 1'b0; enr_we = 1'b0;
        chk(chal_valid && busy, "R9 stray start leaves exchange open", chal_valid, 1);
      end
      resp_data  = (k >= 0) ? resp_of[k] : '0;
      if (mode == 1) resp_data = resp_data ^ 16'h0100;
      resp_valid = 1'b1;
      @(negedge clk);
      resp_valid = 1'b0;
      chk(res_valid && !chal_valid && !busy, "R4 result one cycle after response",
          {res_valid, chal_valid, busy}, 3'b100);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic exh_req();
    exp_pass.push_back(1'b0);
    exp_exh.push_back(1'b1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(res_valid && res_exh && !busy && !chal_valid, "R7 exhausted next cycle",
        {res_valid, res_exh, busy, chal_valid}, 4'b1100);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int spent_k;
    for (int i = 0; i < NL; i++) begin
      chal_of[i] = 16'hA100 + CW'(i * 16'h0111);
      resp_of[i] = chal_of[i] ^ 16'h5A5A ^ RW'(i * 7);
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !chal_valid && !res_valid, "R1 reset state",
        {busy, chal_valid, res_valid}, 0);

    exh_req();                       // R7 on an empty table
    for (int i = 0; i < NL; i++) enroll(i, chal_of[i], resp_of[i]);  // R2
    @(negedge clk);

    auth(0); auth(0); auth(1);       // R4 R5
    auth(2);                         // R8
    auth(3);                         // R9, enrollment while busy ignored (R2)
    auth(1); auth(0);

    spent_k = -1;
    for (int i = 0; i < NL; i++) if (used_m[i] && spent_k < 0) spent_k = i;
    if (spent_k >= 0) enroll(spent_k, 16'hEEEE, 16'h1111);  // R6 reload attempt

    for (int n = 0; n < 5; n++) auth(0);
    chk(rises == NL, "R6 each slot issued once", rises, NL);
    exh_req(); exh_req();            // R7 once all live slots spent
    chk(rises == NL && exp_pass.size() == 0, "R9 no extra challenge or result",
        rises, NL);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule